// File: doc/BRIEF.md
# I2C Register-Access Target with Burst Pointer

This block is an I2C target that gives a bus host byte-wide read and write access to a register map held elsewhere on the chip. SCL and SDA are oversampled by the system clock through a synchroniser and edge detector. The protocol engine tracks START, repeated START and STOP, and it compares the 7-bit address, whose lowest bit comes from a strap input. It acknowledges matching bytes, shifts read data out MSB first, and drives SDA only as an open-drain pull-down enable. It never holds SCL low.

A write-direction transfer first loads a register pointer. Any further bytes in that transfer are written at the pointer, which advances after each byte. A register read uses a write-direction phase to set the pointer, then a repeated START with a read-direction address. The pointer advances after every byte the host acknowledges, and the host ends the read with a NAK and a STOP. Every STOP returns the pointer to 0x00.

The block serves a few addresses itself. The identity register reads a fixed value, and the reserved window reads zero. Sample data is stored as high/low byte pairs for three axes. Reading a high byte captures the matching low byte, so the pair stays coherent when a new sample arrives between the two reads. A fast-read input makes bursts skip the low bytes.

Top module: `i2c_regport_target`

## Requirements
- R1: The target acknowledges (SDA low through the 9th clock) an address byte whose upper seven bits equal 0011100 when `addr_sel`=0, or 0011101 when `addr_sel`=1. On any other address it leaves SDA released, and it ignores all following bytes until the next START or STOP.
- R2: In a write-direction transfer, the first byte after the address loads the pointer. Each later byte produces one `reg_wr_en` pulse at `reg_addr`=pointer with that byte, and then the pointer advances. Every byte is acknowledged.
- R3: After a read-direction address, the target sends the byte at the pointer MSB first. A host ACK advances the pointer and sends the next byte. A host NAK ends the transfer, with SDA released.
- R4: The pointer advances by 1. The exception is `fast_read`=1 with the pointer at 0x01, 0x03 or 0x05, where it advances by 2. A fast burst from 0x00 therefore returns the registers 0x00, 0x01, 0x03 and 0x05.
- R5: Reading a high data byte (0x01, 0x03, 0x05) captures `reg_rd_pair`, which is the register that follows it. A later read of the low byte (0x02, 0x04, 0x06) returns that captured value, even if the source changed in between.
- R6: A random read of a low data byte returns the last captured value for that axis, not the live register.
- R7: A STOP clears the pointer to 0x00. A read-direction transfer with no pointer phase then starts at 0x00.
- R8: Address 0x0D reads 0x2A, and addresses 0x40 to 0x7F read 0x00, whatever the register port returns. The addresses next to these ranges read through the port.
- R9: SDA drive changes only while SCL is low. The block has no SCL output.
- R10: During reset and right after it, SDA is released and neither port strobe is active.
- R11: `reg_rd_en` and `reg_wr_en` are single-cycle pulses and are never active together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 1 | Least significant bit of the target address |
| fast_read | input | 1 | Makes the pointer skip low data bytes |
| reg_rd_en | output | 1 | One-cycle read strobe at `reg_addr` |
| reg_wr_en | output | 1 | One-cycle write strobe at `reg_addr` |
| reg_addr | output | 8 | Current register pointer |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_data | input | 8 | Register content at `reg_addr` |
| reg_rd_pair | input | 8 | Register content at `reg_addr`+1 |

## Verification
The bench changes a low data byte while the high byte of the same axis is on the wire. A design with no capture, or with the capture taken at the wrong moment, would return the new value. It runs bursts from 0x00 with fast-read on and off, which catches a pointer that skips in the wrong mode or by the wrong step. It sends a wrong address followed by a byte that looks like a write, which exposes a target that still acknowledges or writes. It reads without a pointer phase after a STOP, which shows a pointer that survives the STOP. The boundary addresses around the identity register and the reserved window catch off-by-one range decodes.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_RX,
        ST_WR_ACK,
        ST_RD_TX,
        ST_RD_MACK,
        ST_WAIT
    } tgt_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // offset of a pointer from the first data byte, wraps below it
    function automatic byte_t data_offset(input byte_t p, input byte_t first);
        return p - first;
    endfunction

    function automatic logic in_data_range(input byte_t p, input byte_t first, input int axes);
        byte_t off;
        off = data_offset(p, first);
        return (p >= first) && (int'(off) < 2 * axes);
    endfunction

    // next pointer value; fast mode jumps over the low byte of each pair
    function automatic byte_t ptr_step(input byte_t p, input logic fast,
                                       input byte_t first, input int axes);
        byte_t off;
        off = data_offset(p, first);
        if (fast && in_data_range(p, first, axes) && !off[0])
            return p + 8'd2;
        return p + 8'd1;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], line_i};
    end

    assign line_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_monitor.sv
`timescale 1ns/1ps
module i2c_bus_monitor
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw, synced;
    logic              scl_p, sda_p;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk    (clk),
            .rst    (rst),
            .line_i (raw[g]),
            .line_o (synced[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= synced[1];
            sda_p <= synced[0];
        end
    end

    always_comb begin
        evt_o.scl      = synced[1];
        evt_o.sda      = synced[0];
        evt_o.scl_rise = synced[1] & ~scl_p;
        evt_o.scl_fall = ~synced[1] & scl_p;
        evt_o.start    = synced[1] & scl_p & sda_p & ~synced[0];
        evt_o.stop     = synced[1] & scl_p & ~sda_p & synced[0];
    end
endmodule

// File: rtl/i2c_ptr_unit.sv
`timescale 1ns/1ps
module i2c_ptr_unit
    import i2c_tgt_pkg::*;
#(
    parameter byte_t DATA_FIRST = 8'h01,
    parameter int    NUM_AXES   = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clear_i,
    input  logic  load_i,
    input  byte_t load_val_i,
    input  logic  adv_i,
    input  logic  fast_i,
    output byte_t ptr_o
);
    byte_t ptr_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) ptr_q <= '0;
        else if (load_i)    ptr_q <= load_val_i;
        else if (adv_i)     ptr_q <= ptr_step(ptr_q, fast_i, DATA_FIRST, NUM_AXES);
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_read_path.sv
`timescale 1ns/1ps
module i2c_read_path
    import i2c_tgt_pkg::*;
#(
    parameter byte_t DATA_FIRST = 8'h01,
    parameter int    NUM_AXES   = 3,
    parameter byte_t ID_ADDR    = 8'h0D,
    parameter byte_t ID_VALUE   = 8'h2A,
    parameter byte_t RSV_LO     = 8'h40,
    parameter byte_t RSV_HI     = 8'h7F
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  fetch_i,
    input  byte_t ptr_i,
    input  byte_t port_data_i,
    input  byte_t port_pair_i,
    output logic  port_rd_en_o,
    output byte_t byte_o
);
    byte_t off;
    logic  in_rng, is_hi, is_lo, is_id, is_rsv;
    byte_t snap_all [NUM_AXES];

    assign off    = data_offset(ptr_i, DATA_FIRST);
    assign in_rng = in_data_range(ptr_i, DATA_FIRST, NUM_AXES);
    assign is_hi  = in_rng & ~off[0];
    assign is_lo  = in_rng & off[0];
    assign is_id  = (ptr_i == ID_ADDR);
    assign is_rsv = (ptr_i >= RSV_LO) && (ptr_i <= RSV_HI);

    // one capture register per axis, loaded when its high byte is fetched
    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        byte_t snap_q;
        always_ff @(posedge clk) begin
            if (rst) snap_q <= '0;
            else if (fetch_i && is_hi && (off[7:1] == 7'(a))) snap_q <= port_pair_i;
        end
        assign snap_all[a] = snap_q;
    end

    always_comb begin
        byte_o = port_data_i;
        if (is_id)       byte_o = ID_VALUE;
        else if (is_rsv) byte_o = '0;
        else if (is_lo) begin
            for (int a = 0; a < NUM_AXES; a++)
                if (off[7:1] == 7'(a)) byte_o = snap_all[a];
        end
    end

    assign port_rd_en_o = fetch_i & ~is_id & ~is_rsv & ~is_lo;
endmodule

// File: rtl/i2c_regport_target.sv
`timescale 1ns/1ps
module i2c_regport_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR_BASE = 7'b0011100,
    parameter int         SYNC_STAGES   = 2,
    parameter byte_t      DATA_FIRST    = 8'h01,
    parameter int         NUM_AXES      = 3,
    parameter byte_t      ID_ADDR       = 8'h0D,
    parameter byte_t      ID_VALUE      = 8'h2A,
    parameter byte_t      RSV_LO        = 8'h40,
    parameter byte_t      RSV_HI        = 8'h7F
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       addr_sel,
    input  logic       fast_read,
    output logic       reg_rd_en,
    output logic       reg_wr_en,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wr_data,
    input  logic [7:0] reg_rd_data,
    input  logic [7:0] reg_rd_pair
);
    localparam int         CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(BYTE_W);

    bus_evt_t   ev;
    tgt_state_e state;
    logic [CNT_W-1:0] bit_cnt;
    byte_t      rx_sh, tx_sh, ptr, rd_byte;
    logic       sda_oe_q, rw_q, ptr_phase, fetch_q;
    logic       ptr_load, ptr_adv, byte_end;
    logic       scl_sync, evt_start, evt_stop;

    i2c_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) i_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (ev)
    );

    assign scl_sync  = ev.scl;
    assign evt_start = ev.start;
    assign evt_stop  = ev.stop;

    assign byte_end  = ev.scl_fall && (bit_cnt == BYTE_DONE);
    assign reg_wr_en = (state == ST_WR_RX) && byte_end && !ptr_phase && !ev.stop && !ev.start;
    assign ptr_load  = (state == ST_WR_RX) && byte_end && ptr_phase && !ev.stop && !ev.start;
    assign ptr_adv   = reg_wr_en || ((state == ST_RD_MACK) && ev.scl_rise && !ev.sda);

    i2c_ptr_unit #(.DATA_FIRST(DATA_FIRST), .NUM_AXES(NUM_AXES)) i_ptr (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (ev.stop),
        .load_i     (ptr_load),
        .load_val_i (rx_sh),
        .adv_i      (ptr_adv),
        .fast_i     (fast_read),
        .ptr_o      (ptr)
    );

    i2c_read_path #(
        .DATA_FIRST (DATA_FIRST),
        .NUM_AXES   (NUM_AXES),
        .ID_ADDR    (ID_ADDR),
        .ID_VALUE   (ID_VALUE),
        .RSV_LO     (RSV_LO),
        .RSV_HI     (RSV_HI)
    ) i_rd (
        .clk          (clk),
        .rst          (rst),
        .fetch_i      (fetch_q),
        .ptr_i        (ptr),
        .port_data_i  (reg_rd_data),
        .port_pair_i  (reg_rd_pair),
        .port_rd_en_o (reg_rd_en),
        .byte_o       (rd_byte)
    );

    assign reg_addr    = ptr;
    assign reg_wr_data = rx_sh;
    assign sda_oe      = sda_oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            sda_oe_q  <= 1'b0;
            rw_q      <= 1'b0;
            ptr_phase <= 1'b0;
            fetch_q   <= 1'b0;
        end else begin
            fetch_q <= 1'b0;
            if (fetch_q) tx_sh <= rd_byte;

            if (ev.stop) begin
                state    <= ST_IDLE;
                sda_oe_q <= 1'b0;
            end else if (ev.start) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                sda_oe_q <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_WAIT: ;
                    ST_ADDR, ST_WR_RX: begin
                        if (ev.scl_rise && (bit_cnt < BYTE_DONE)) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], ev.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_end) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (rx_sh[7:1] == {DEV_ADDR_BASE[6:1], addr_sel}) begin
                                    sda_oe_q  <= 1'b1;
                                    rw_q      <= rx_sh[0];
                                    ptr_phase <= ~rx_sh[0];
                                    fetch_q   <= rx_sh[0];
                                    state     <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end else begin
                                sda_oe_q  <= 1'b1;
                                ptr_phase <= 1'b0;
                                state     <= ST_WR_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            if (rw_q) begin
                                sda_oe_q <= ~tx_sh[BYTE_W-1];
                                tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                                bit_cnt  <= CNT_W'(1);
                                state    <= ST_RD_TX;
                            end else begin
                                sda_oe_q <= 1'b0;
                                state    <= ST_WR_RX;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe_q <= 1'b0;
                            state    <= ST_WR_RX;
                        end
                    end
                    ST_RD_TX: begin
                        if (ev.scl_fall) begin
                            if (bit_cnt < BYTE_DONE) begin
                                sda_oe_q <= ~tx_sh[BYTE_W-1];
                                tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                                bit_cnt  <= bit_cnt + 1'b1;
                            end else begin
                                sda_oe_q <= 1'b0;
                                bit_cnt  <= '0;
                                state    <= ST_RD_MACK;
                            end
                        end
                    end
                    ST_RD_MACK: begin
                        if (ev.scl_rise) begin
                            if (ev.sda) state   <= ST_WAIT;
                            else        fetch_q <= 1'b1;
                        end else if (ev.scl_fall) begin
                            sda_oe_q <= ~tx_sh[BYTE_W-1];
                            tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                            bit_cnt  <= CNT_W'(1);
                            state    <= ST_RD_TX;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regport_target_chk.sv
`timescale 1ns/1ps
module i2c_regport_target_chk
    import i2c_tgt_pkg::*;
#(
    parameter byte_t DATA_FIRST = 8'h01
) (
    input logic       clk,
    input logic       rst,
    input logic       sda_oe,
    input logic       scl_sync,
    input logic       evt_start,
    input logic       evt_stop,
    input logic       reg_rd_en,
    input logic       reg_wr_en,
    input logic       fast_read,
    input logic       ptr_adv,
    input byte_t      ptr,
    input tgt_state_e state
);
    // R9
    sda_quiet_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_sync && $past(scl_sync) && !$past(evt_stop) && !$past(evt_start))
        |-> $stable(sda_oe));

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd_en && reg_wr_en));

    // R11
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |=> !reg_rd_en);

    // R7
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        evt_stop |=> (ptr == 8'h00));

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT || state == ST_IDLE) |-> !sda_oe);

    // R4
    fast_skip_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ptr_adv) && $past(fast_read) && !$past(evt_stop) && ($past(ptr) == DATA_FIRST))
        |-> (ptr == DATA_FIRST + 8'd2));
endmodule

bind i2c_regport_target i2c_regport_target_chk #(.DATA_FIRST(DATA_FIRST)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe),
    .scl_sync  (scl_sync),
    .evt_start (evt_start),
    .evt_stop  (evt_stop),
    .reg_rd_en (reg_rd_en),
    .reg_wr_en (reg_wr_en),
    .fast_read (fast_read),
    .ptr_adv   (ptr_adv),
    .ptr       (ptr),
    .state     (state)
);

// File: tb/test_i2c_regport_target.sv
`timescale 1ns/1ps
module test_i2c_regport_target;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0, fast_read = 1'b0;
    logic sda_oe, reg_rd_en, reg_wr_en;
    logic [7:0] reg_addr, reg_wr_data, reg_rd_data, reg_rd_pair;
    wire  sda_line = sda_m & ~sda_oe;

    logic [7:0] mem [256];
    logic [7:0] snap_m [3];
    logic [7:0] rbuf [8];
    logic [7:0] ebuf [8];
    int checks = 0, failures = 0, sda_viol = 0, strobe_viol = 0;
    logic done = 1'b0;
    logic scl_d = 1'b1, oe_d = 1'b0, rd_d = 1'b0;

    assign reg_rd_data = mem[reg_addr];
    assign reg_rd_pair = mem[reg_addr + 8'd1];
    always @(posedge clk) if (reg_wr_en) mem[reg_addr] <= reg_wr_data;

    i2c_regport_target i_i2c_regport_target (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .fast_read(fast_read), .reg_rd_en(reg_rd_en),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .reg_rd_pair(reg_rd_pair)
    );

    // R9 / R11 monitors
    always @(negedge clk) begin
        if (!rst) begin
            if (scl_m && scl_d && (sda_oe != oe_d)) sda_viol++;
            if (reg_rd_en && (reg_wr_en || rd_d)) strobe_viol++;
        end
        scl_d = scl_m; oe_d = sda_oe; rd_d = reg_rd_en;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq(); hq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
        end
        sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); ack = ~sda_line; hq(); scl_m = 1'b0; hq();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hq(); scl_m = 1'b1; hq(); b[i] = sda_line; hq(); scl_m = 1'b0;
        end
        hq(); sda_m = ~mack; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev(input logic rw);
        return {6'b001110, addr_sel, rw};
    endfunction

    function automatic logic [7:0] step(input logic [7:0] p);
        if (fast_read && (p == 8'h01 || p == 8'h03 || p == 8'h05)) return p + 8'd2;
        return p + 8'd1;
    endfunction

    // expected read value, with the bench's own capture model
    task automatic exp_byte(input logic [7:0] a, output logic [7:0] e);
        if (a == 8'h0D) e = 8'h2A;
        else if (a >= 8'h40 && a <= 8'h7F) e = 8'h00;
        else if (a == 8'h02 || a == 8'h04 || a == 8'h06) e = snap_m[(a - 8'd2) >> 1];
        else begin
            e = mem[a];
            if (a == 8'h01 || a == 8'h03 || a == 8'h05) snap_m[(a - 8'd1) >> 1] = mem[a + 8'd1];
        end
    endtask

    task automatic wr_burst(input logic [7:0] p, input int n, input string req);
        logic a;
        bus_start();
        send_byte(dev(1'b0), a); chk({req, " addr ack"}, a, 1);
        send_byte(p, a);
        for (int k = 0; k < n; k++) begin
            send_byte(ebuf[k], a); chk({req, " data ack"}, a, 1);
        end
        bus_stop();
    endtask

    task automatic rd_burst(input logic use_ptr, input logic [7:0] p, input int n);
        logic a;
        bus_start();
        if (use_ptr) begin
            send_byte(dev(1'b0), a); send_byte(p, a); bus_start();
        end
        send_byte(dev(1'b1), a);
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
        bus_stop();
    endtask

    task automatic rd_expect(input logic use_ptr, input logic [7:0] p, input int n, input string req);
        logic [7:0] q;
        logic [7:0] e [8];
        q = p;
        for (int k = 0; k < n; k++) begin exp_byte(q, e[k]); q = step(q); end
        rd_burst(use_ptr, p, n);
        for (int k = 0; k < n; k++) chk(req, rbuf[k], e[k]);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL R3 watchdog actual=hung expected=done");
            report();
        end
    end

    initial begin
        logic a;
        logic [7:0] g0, g1;
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        for (int i = 0; i < 3; i++) snap_m[i] = 8'h00;
        repeat (6) @(negedge clk);
        // R10 reset state
        chk("R10 reset strobes/sda", {sda_oe, reg_rd_en, reg_wr_en}, 3'b000);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 after reset", {sda_oe, reg_rd_en, reg_wr_en}, 3'b000);

        // R1 mismatch: wrong address, then a pointer byte and data
        mem[8'h20] = 8'h11;
        bus_start();
        send_byte({7'b0011101, 1'b0}, a); chk("R1 wrong addr nack", a, 0);
        send_byte(8'h20, a); chk("R1 ignored byte nack", a, 0);
        send_byte(8'h99, a);
        bus_stop();
        chk("R1 ignored write", mem[8'h20], 8'h11);

        // R1 with addr_sel high
        addr_sel = 1'b1;
        ebuf[0] = 8'h5A;
        wr_burst(8'h21, 1, "R1 sel1");
        chk("R1 sel1 write", mem[8'h21], 8'h5A);
        addr_sel = 1'b0;

        // R2 write burst, R3 read back
        ebuf[0] = 8'hC1; ebuf[1] = 8'hC2; ebuf[2] = 8'hC3;
        wr_burst(8'h30, 3, "R2");
        chk("R2 byte0", mem[8'h30], 8'hC1);
        chk("R2 byte2", mem[8'h32], 8'hC3);
        rd_expect(1'b1, 8'h30, 3, "R3 burst");

        // R7: read with no pointer phase starts at 0x00
        rd_expect(1'b0, 8'h00, 2, "R7 after stop");

        // R8 identity, reserved window and its neighbours
        mem[8'h0D] = 8'h55; mem[8'h40] = 8'h77; mem[8'h7F] = 8'h78;
        rd_burst(1'b1, 8'h0D, 1); chk("R8 identity", rbuf[0], 8'h2A);
        rd_burst(1'b1, 8'h3F, 2); chk("R8 below window", rbuf[0], mem[8'h3F]);
        chk("R8 window low", rbuf[1], 8'h00);
        rd_burst(1'b1, 8'h7F, 2); chk("R8 window high", rbuf[0], 8'h00);
        chk("R8 above window", rbuf[1], mem[8'h80]);

        // R4 fast and normal bursts from 0x00
        fast_read = 1'b1;
        rd_expect(1'b1, 8'h00, 4, "R4 fast burst");
        fast_read = 1'b0;
        rd_expect(1'b1, 8'h00, 7, "R4 normal burst");

        // R5 coherence: low byte changes while high byte is on the wire
        mem[8'h01] = 8'hA1; mem[8'h02] = 8'hB2;
        bus_start();
        send_byte(dev(1'b0), a); send_byte(8'h01, a); bus_start();
        send_byte(dev(1'b1), a);
        fork
            recv_byte(1'b1, g0);
            begin repeat (20) @(negedge clk); mem[8'h02] = 8'hC3; end
        join
        recv_byte(1'b0, g1);
        bus_stop();
        chk("R5 high byte", g0, 8'hA1);
        chk("R5 coherent low", g1, 8'hB2);
        snap_m[0] = 8'hB2;

        // R6 random low-byte read returns capture
        mem[8'h02] = 8'hD4;
        rd_burst(1'b1, 8'h02, 1); chk("R6 random low", rbuf[0], 8'hB2);

        // random write / read-back bursts (R2, R3)
        for (int it = 0; it < 14; it++) begin
            logic [7:0] p;
            int n;
            p = 8'h10 + 8'($urandom_range(0, 39));
            n = $urandom_range(1, 4);
            for (int k = 0; k < n; k++) ebuf[k] = 8'($urandom);
            wr_burst(p, n, "R2 rand");
            for (int k = 0; k < n; k++) chk("R2 rand mem", mem[p + 8'(k)], ebuf[k]);
            rd_expect(1'b1, p, n, "R3 rand readback");
        end

        // random sample data with fast mode on and off (R4, R5)
        for (int it = 0; it < 8; it++) begin
            for (int r = 0; r <= 6; r++) mem[r] = 8'($urandom);
            fast_read = 1'($urandom);
            rd_expect(1'b1, 8'h00, fast_read ? 4 : 7, "R4 rand data burst");
        end
        fast_read = 1'b0;

        chk("R9 sda changed with scl high", sda_viol, 0);
        chk("R11 strobe overlap or width", strobe_viol, 0);
        done = 1'b1;
        report();
    end
endmodule